// File: doc/BRIEF.md
# Phase Snapshot Fine-Time Encoder

This block turns a latched picture of sixteen evenly spaced clock phases into a 4-bit fine-time code. The phases are spread over one period of the base clock, one sixteenth of a period apart (about 579 ps at 108 MHz). Sampled together, they form a circular pattern: a contiguous run of ones whose position moves round the ring as the sampling instant slides through the period. The block reads that pattern as a thermometer code ordered in time. It finds where the run begins, and that position is the fine part of a time measurement. The coarse count and this code together make up the converted value, with this code in the least significant bits.

A conversion controller asserts a one-cycle encode strobe while the snapshot is steady. One clock later the block returns the code and raises a done flag for one cycle. Before the boundary search, each phase bit passes through a three-input majority vote with its two circular neighbours. This removes isolated bubbles caused by metastable or slow samples. If the filtered pattern has no start-of-run or more than one, the block returns code 0 and raises an error flag.

Top module: `phase_therm_encoder`

## Requirements
- R1: After reset, and until the first sampled strobe, done_o, err_o and code_o are all zero.
- R2: done_o is high in the cycle after every clock edge that samples start_i high. It is low in the cycle after every edge that samples start_i low, so back-to-back strobes give back-to-back done pulses.
- R3: Bit i of phase_i is the state of phase i. On a strobe, the block encodes the filtered vector. A start-of-run is an index i whose filtered bit is 1 while filtered bit (i-1) mod 16 is 0. When exactly one start-of-run exists, code_o becomes i and err_o becomes 0.
- R4: Before detection, each bit i is replaced by the majority of raw bits (i-1) mod 16, i and (i+1) mod 16. A lone 1 or a lone 0 inside a run of two or more therefore does not change the code.
- R5: If the filtered vector is all zeros or all ones, code_o becomes 0 and err_o becomes 1.
- R6: If the filtered vector has two or more starts-of-run, code_o becomes 0 and err_o becomes 1.
- R7: On an edge where start_i is low, code_o and err_o keep their values, whatever phase_i does.
- R8: The neighbour relation wraps around. A run that crosses from phase 15 to phase 0 encodes as the index where it starts, and the majority vote for bits 0 and 15 uses the bits on the far side of the ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Encode strobe; the snapshot is sampled on the same edge |
| phase_i | input | 16 | Latched phase snapshot, bit i = phase i |
| done_o | output | 1 | One-cycle pulse: a new result is on code_o and err_o |
| code_o | output | 4 | Fine-time code |
| err_o | output | 1 | Snapshot had no single start-of-run |

## Verification
The assertions assume that phase_i is stable at the clock edge that samples start_i. They make no assumption about how long the run is or where it sits. An unfiltered pattern may contain bubbles, and the checks still hold because they relate the detector's start-of-run vector to the error flag, not to the raw input. The stimulus changes phase_i only at the falling clock edge. It covers every rotation of a half-ring run, bubbled runs, short runs, empty and full rings and split runs, and it toggles phase_i during idle cycles to exercise the hold rule.

// File: rtl/phase_enc_pkg.sv
package phase_enc_pkg;

    localparam int DEF_PHASES = 16;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/phase_bubble_filter.sv
module phase_bubble_filter #(
    parameter int NPH = phase_enc_pkg::DEF_PHASES
) (
    input  logic [NPH-1:0] raw_i,
    output logic [NPH-1:0] filt_o
);
    import phase_enc_pkg::*;

    for (genvar g = 0; g < NPH; g++) begin : g_vote
        localparam int LO = (g + NPH - 1) % NPH;
        localparam int HI = (g + 1) % NPH;
        assign filt_o[g] = vote3(raw_i[LO], raw_i[g], raw_i[HI]);
    end

endmodule

// File: rtl/phase_edge_finder.sv
module phase_edge_finder #(
    parameter int NPH = phase_enc_pkg::DEF_PHASES,
    localparam int CW = $clog2(NPH),
    localparam int NW = $clog2(NPH + 1)
) (
    input  logic [NPH-1:0] filt_i,
    output logic [NPH-1:0] rise_o,
    output logic [CW-1:0]  idx_o,
    output logic           single_o
);
    logic [NW-1:0] rise_cnt;

    for (genvar g = 0; g < NPH; g++) begin : g_rise
        localparam int PREV = (g + NPH - 1) % NPH;
        assign rise_o[g] = filt_i[g] & ~filt_i[PREV];
    end

    always_comb begin
        idx_o    = '0;
        rise_cnt = '0;
        for (int i = 0; i < NPH; i++) begin
            if (rise_o[i]) begin
                idx_o    = idx_o | i[CW-1:0];
                rise_cnt = rise_cnt + NW'(1);
            end
        end
        single_o = (rise_cnt == NW'(1));
    end

endmodule

// File: rtl/phase_therm_encoder.sv
module phase_therm_encoder #(
    parameter int NPH = phase_enc_pkg::DEF_PHASES,
    localparam int CW = $clog2(NPH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [NPH-1:0] phase_i,
    output logic           done_o,
    output logic [CW-1:0]  code_o,
    output logic           err_o
);
    typedef struct packed {
        logic          done;
        logic          err;
        logic [CW-1:0] code;
    } enc_state_t;

    enc_state_t    st_d, st_q;
    logic [NPH-1:0] filt_vec;
    logic [NPH-1:0] rise_vec;
    logic [CW-1:0]  rise_idx;
    logic           one_rise;

    phase_bubble_filter #(.NPH(NPH)) u_filter (
        .raw_i  (phase_i),
        .filt_o (filt_vec)
    );

    phase_edge_finder #(.NPH(NPH)) u_finder (
        .filt_i   (filt_vec),
        .rise_o   (rise_vec),
        .idx_o    (rise_idx),
        .single_o (one_rise)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start_i;
        if (start_i) begin
            st_d.err  = ~one_rise;
            st_d.code = one_rise ? rise_idx : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign code_o = st_q.code;
    assign err_o  = st_q.err;

    assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    assert_no_stray_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(code_o) && $stable(err_o)));
    assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && $countones(rise_vec) == 1) |=> (!err_o && code_o == $past(rise_idx)));
    assert_flat_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (filt_vec == '0 || filt_vec == '1)) |=> (err_o && code_o == '0));
    assert_multi_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && $countones(rise_vec) > 1) |=> (err_o && code_o == '0));

endmodule

// File: tb/phase_therm_encoder_bench.sv
module phase_therm_encoder_bench;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [N-1:0] phase_i = '0;
    logic         done_o;
    logic [3:0]   code_o;
    logic         err_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 0;

    logic       exp_done = 0;
    logic [3:0] exp_code = 0;
    logic       exp_err = 0;

    always #2 clk = ~clk;

    phase_therm_encoder u_phase_therm_encoder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_i(phase_i),
        .done_o(done_o), .code_o(code_o), .err_o(err_o)
    );

    function automatic void model(input logic [N-1:0] v, output logic [3:0] c, output logic e);
        int f[N];
        int rises = 0;
        int where = 0;
        for (int i = 0; i < N; i++) begin
            int s = int'(v[(i+N-1)%N]) + int'(v[i]) + int'(v[(i+1)%N]);
            f[i] = (s >= 2) ? 1 : 0;
        end
        for (int i = 0; i < N; i++) begin
            if (f[i] == 1 && f[(i+N-1)%N] == 0) begin
                rises++;
                where = i;
            end
        end
        if (rises == 1) begin c = 4'(where); e = 0; end
        else            begin c = 0; e = 1; end
    endfunction

    function automatic logic [N-1:0] run(input int first, input int len);
        logic [N-1:0] r = '0;
        for (int k = 0; k < len; k++) r[(first+k)%N] = 1'b1;
        return r;
    endfunction

    task automatic compare(input string tag);
        n_cmp++;
        if (done_o !== exp_done || code_o !== exp_code || err_o !== exp_err) begin
            n_bad++;
            $display("FAIL %s: done/code/err actual %b/%0d/%b expected %b/%0d/%b",
                     tag, done_o, code_o, err_o, exp_done, exp_code, exp_err);
        end
    endtask

    task automatic step(input logic s, input logic [N-1:0] v, input string tag);
        logic [3:0] c;
        logic e;
        start_i = s;
        phase_i = v;
        exp_done = s;
        if (s) begin
            model(v, c, e);
            exp_code = c;
            exp_err = e;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");
        step(1'b0, 16'hFFFF, "R1 idle before first strobe");

        for (int p = 0; p < N; p++) step(1'b1, run(p, 8), "R3 rotation");
        for (int p = 9; p < N; p++) step(1'b1, run(p, 5), "R8 wrap run");
        step(1'b1, run(5, 2), "R3 short run");
        step(1'b1, run(3, 14), "R3 long run");

        step(1'b1, run(4, 8) | 16'h4000, "R4 lone one");
        step(1'b1, run(4, 8) & ~16'h0080, "R4 lone zero");
        step(1'b1, run(12, 8) | 16'h0100, "R4 R8 lone one near wrap");
        step(1'b1, 16'h8001 | 16'h0004, "R8 vote across ring");

        step(1'b1, 16'h0000, "R5 all zero");
        step(1'b1, 16'hFFFF, "R5 all one");
        step(1'b1, 16'h0001, "R5 lone bit filtered away");
        step(1'b1, run(0, 4) | run(8, 4), "R6 two runs");
        step(1'b1, run(1, 3) | run(6, 3) | run(11, 3), "R6 three runs");

        step(1'b1, run(6, 8), "R7 load");
        for (int k = 0; k < 5; k++) step(1'b0, 16'(k * 16'h1357), "R7 idle hold");
        step(1'b1, 16'h0000, "R7 load err");
        step(1'b0, run(2, 8), "R7 idle hold err");
        step(1'b1, run(10, 8), "R2 back to back");
        step(1'b1, run(11, 8), "R2 back to back");
        step(1'b0, run(11, 8), "R2 done drops");
        step(1'b0, run(11, 8), "R2 done stays low");

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule